// File: doc/BRIEF.md
# GPIO Port with Per-Pin Peripheral Overrides

This block is an eight-pin general-purpose I/O port. Software-style registers set each pin's direction and output level, and also its pull-up. A global bit can switch off every register-requested pull-up at once. Beside the registers, each pin accepts four override pairs from peripherals. Each pair is one enable bit and one value bit. The pairs let a peripheral take over, pin by pin, the pull-up, the output driver enable, the driven value and the digital input gating. All override paths are combinational and add no latency.

The pad is modelled as four plain signals: driven value, driver enable, pull-up enable and raw input. The raw input is gated by the pin's digital-input enable. That enable comes from the sleep state unless it is overridden. The gated input then feeds two places. The first is a two-flop synchronizer, whose output is the readable pin register. The second is a direct, unsynchronized tap for alternate functions; a peripheral using that tap must synchronize it itself.

A per-pin hazard flag marks a driven output that toggles on a pin selected as an analog input while a conversion is busy.

Top module: `gpio_override_port`

## Requirements
- R1: After reset, the direction register, the port register and the pull-up-disable bit are all 0. With no overrides, pad_oe, pad_pu and pad_out are 0.
- R2: With ov_pu_en[i]=0, pad_pu[i] is 1 exactly when dir[i]=0, port[i]=1 and the pull-up-disable bit is 0.
- R3: With ov_pu_en[i]=1, pad_pu[i] equals ov_pu_val[i], whatever the register bits hold.
- R4: pad_oe[i] equals ov_dir_val[i] when ov_dir_en[i]=1. Otherwise it equals dir[i].
- R5: pad_out[i] is 0 while pad_oe[i]=0. While pad_oe[i]=1, pad_out[i] is ov_pv_val[i] when ov_pv_en[i]=1, and port[i] otherwise.
- R6: The digital-input enable of pin i is ov_die_val[i] when ov_die_en[i]=1. Otherwise it is 1 when sleep=0 and 0 when sleep=1.
- R7: alt_din[i] equals pad_in[i] AND the pin's digital-input enable, combinationally, with no register in the path.
- R8: rd_pin shows the gated input two clock edges after it is sampled; its reset value is 0.
- R9: A write with wr_en=1 loads wr_data into a register chosen by wr_sel: 0 selects the direction register, 1 the port register, and 2 the pull-up-disable bit (from wr_data[0]). wr_sel=3 changes nothing. rd_dir, rd_port and rd_pud show the registers.
- R10: analog_hazard[i] is 1 in a cycle where conv_busy=1, analog_sel[i]=1, pad_oe[i]=1 and pad_out[i] differs from its value at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 direction, 1 port, 2 pull-up disable |
| wr_data | input | 8 | Write data |
| rd_dir | output | 8 | Direction register |
| rd_port | output | 8 | Port output / pull-up register |
| rd_pud | output | 1 | Global pull-up disable bit |
| rd_pin | output | 8 | Synchronized pin input |
| sleep | input | 1 | Sleep state; disables inputs without override |
| ov_pu_en | input | 8 | Pull-up override enable |
| ov_pu_val | input | 8 | Pull-up override value |
| ov_dir_en | input | 8 | Direction override enable |
| ov_dir_val | input | 8 | Direction override value |
| ov_pv_en | input | 8 | Output value override enable |
| ov_pv_val | input | 8 | Output value override value |
| ov_die_en | input | 8 | Digital input enable override enable |
| ov_die_val | input | 8 | Digital input enable override value |
| pad_in | input | 8 | Raw pad input |
| pad_out | output | 8 | Value driven to pad |
| pad_oe | output | 8 | Pad driver enable |
| pad_pu | output | 8 | Pad pull-up enable |
| alt_din | output | 8 | Unsynchronized gated input for peripherals |
| conv_busy | input | 1 | Analog conversion in progress |
| analog_sel | input | 8 | Pins used as analog inputs |
| analog_hazard | output | 8 | Output toggled on a busy analog pin |

## Verification
The assertions check the override paths on every cycle: the pull-up, driver-enable, driven-value and input-gating overrides. They also check the two-edge delay from the alternate-function tap to the readable pin register.

The bench's behavioural model covers what those properties cannot see. This includes the 3'b010 pull-up decode under the disable bit, sleep gating when no override is set, the ignored register select, reset values, and the hazard flag raised by deliberate toggles during a conversion.

// File: rtl/gpio_override_port.sv
module gpio_override_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_dir,
  output logic [W-1:0] rd_port,
  output logic         rd_pud,
  output logic [W-1:0] rd_pin,
  input  logic         sleep,
  input  logic [W-1:0] ov_pu_en,
  input  logic [W-1:0] ov_pu_val,
  input  logic [W-1:0] ov_dir_en,
  input  logic [W-1:0] ov_dir_val,
  input  logic [W-1:0] ov_pv_en,
  input  logic [W-1:0] ov_pv_val,
  input  logic [W-1:0] ov_die_en,
  input  logic [W-1:0] ov_die_val,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu,
  output logic [W-1:0] alt_din,
  input  logic         conv_busy,
  input  logic [W-1:0] analog_sel,
  output logic [W-1:0] analog_hazard
);

  localparam logic [1:0] SEL_DIR  = 2'd0;
  localparam logic [1:0] SEL_PORT = 2'd1;
  localparam logic [1:0] SEL_PUD  = 2'd2;

  logic [W-1:0] dir_q, port_q, meta_q, sync_q, out_q;
  logic         pud_q;
  logic [W-1:0] din_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      port_q <= '0;
      pud_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_DIR:  dir_q  <= wr_data;
        SEL_PORT: port_q <= wr_data;
        SEL_PUD:  pud_q  <= wr_data[0];
        default:  ;
      endcase
    end
  end

  assign din_en  = (ov_die_en & ov_die_val) | (~ov_die_en & {W{~sleep}});
  assign pad_pu  = (ov_pu_en & ov_pu_val) | (~ov_pu_en & ~dir_q & port_q & {W{~pud_q}});
  assign pad_oe  = (ov_dir_en & ov_dir_val) | (~ov_dir_en & dir_q);
  assign pad_out = pad_oe & ((ov_pv_en & ov_pv_val) | (~ov_pv_en & port_q));
  assign alt_din = pad_in & din_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      out_q  <= '0;
    end else begin
      meta_q <= alt_din;
      sync_q <= meta_q;
      out_q  <= pad_out;
    end
  end

  assign analog_hazard = {W{conv_busy}} & analog_sel & pad_oe & (pad_out ^ out_q);

  assign rd_dir  = dir_q;
  assign rd_port = port_q;
  assign rd_pud  = pud_q;
  assign rd_pin  = sync_q;

endmodule

module gpio_override_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] ov_pu_en,
  input logic [W-1:0] ov_pu_val,
  input logic [W-1:0] ov_dir_en,
  input logic [W-1:0] ov_dir_val,
  input logic [W-1:0] ov_pv_en,
  input logic [W-1:0] ov_pv_val,
  input logic [W-1:0] ov_die_en,
  input logic [W-1:0] ov_die_val,
  input logic [W-1:0] pad_in,
  input logic [W-1:0] pad_out,
  input logic [W-1:0] pad_oe,
  input logic [W-1:0] pad_pu,
  input logic [W-1:0] alt_din,
  input logic [W-1:0] rd_pin
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd2) age <= age + 2'd1;

  AST_PU_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu ^ ov_pu_val) & ov_pu_en) == '0); // R3
  AST_DIR_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe ^ ov_dir_val) & ov_dir_en) == '0); // R4
  AST_VALUE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out ^ ov_pv_val) & ov_pv_en & pad_oe) == '0); // R5
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_out & ~pad_oe) == '0); // R5
  AST_DIE_FORCED_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_din ^ pad_in) & ov_die_en & ov_die_val) == '0); // R6
  AST_DIE_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_din & ov_die_en & ~ov_die_val) == '0); // R6
  AST_TAP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_din & ~pad_in) == '0); // R7
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n || age != 2'd2)
    rd_pin == $past(alt_din, 2)); // R8
endmodule

bind gpio_override_port gpio_override_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ov_pu_en(ov_pu_en), .ov_pu_val(ov_pu_val),
  .ov_dir_en(ov_dir_en), .ov_dir_val(ov_dir_val),
  .ov_pv_en(ov_pv_en), .ov_pv_val(ov_pv_val),
  .ov_die_en(ov_die_en), .ov_die_val(ov_die_val),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
  .alt_din(alt_din), .rd_pin(rd_pin)
);

// File: tb/gpio_override_port_bench.sv
`timescale 1ns/1ps
module gpio_override_port_bench;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [W-1:0] wr_data = 0;
  logic sleep = 0, conv_busy = 0;
  logic [W-1:0] ov_pu_en = 0, ov_pu_val = 0, ov_dir_en = 0, ov_dir_val = 0;
  logic [W-1:0] ov_pv_en = 0, ov_pv_val = 0, ov_die_en = 0, ov_die_val = 0;
  logic [W-1:0] pad_in = 0, analog_sel = 0;
  logic [W-1:0] rd_dir, rd_port, rd_pin, pad_out, pad_oe, pad_pu, alt_din, analog_hazard;
  logic rd_pud;

  gpio_override_port u_gpio_override_port (.*);

  int checks = 0, fails = 0;
  logic [W-1:0] m_dir = 0, m_port = 0, m_prev = 0;
  logic m_pud = 0;
  logic [W-1:0] hist[$];
  logic [W-1:0] e_pu, e_oe, e_out, e_die, e_alt, e_haz;

  function automatic void expect_now();
    for (int i = 0; i < W; i++) begin
      e_die[i] = ov_die_en[i] ? ov_die_val[i] : !sleep;
      e_pu[i]  = ov_pu_en[i] ? ov_pu_val[i] : ({m_dir[i], m_port[i], m_pud} == 3'b010);
      e_oe[i]  = ov_dir_en[i] ? ov_dir_val[i] : m_dir[i];
      e_out[i] = e_oe[i] ? (ov_pv_en[i] ? ov_pv_val[i] : m_port[i]) : 1'b0;
      e_alt[i] = pad_in[i] && e_die[i];
      e_haz[i] = conv_busy && analog_sel[i] && e_oe[i] && (e_out[i] != m_prev[i]);
    end
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model state update
  always @(posedge clk) begin
    expect_now();
    if (!rst_n) begin
      m_dir <= 0; m_port <= 0; m_pud <= 0; m_prev <= 0; hist = {0, 0};
    end else begin
      if (wr_en && wr_sel == 2'd0) m_dir <= wr_data;
      if (wr_en && wr_sel == 2'd1) m_port <= wr_data;
      if (wr_en && wr_sel == 2'd2) m_pud <= wr_data[0];
      m_prev <= e_out;
      hist.push_back(e_alt);
      void'(hist.pop_front());
    end
  end

  // every-cycle comparison away from the edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      expect_now();
      chk("R9 dir", rd_dir, m_dir);
      chk("R9 port", rd_port, m_port);
      chk("R9 pud", {7'd0, rd_pud}, {7'd0, m_pud});
      chk("R2 R3 pullup", pad_pu, e_pu);
      chk("R4 oe", pad_oe, e_oe);
      chk("R5 out", pad_out, e_out);
      chk("R6 R7 alt_din", alt_din, e_alt);
      chk("R8 rd_pin", rd_pin, hist[0]);
      chk("R10 hazard", analog_hazard, e_haz);
    end
  end

  task automatic wr(logic [1:0] s, logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    hist = {0, 0};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset oe", pad_oe, 0);
    chk("R1 reset pu", pad_pu, 0);
    chk("R1 reset dir", rd_dir, 0);
    chk("R1 reset pin", rd_pin, 0);
    @(negedge clk); rst_n = 1;
    repeat (2) @(negedge clk);
    // R2: pull-up decode
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h3C);
    wr(2'd2, 8'h01);
    wr(2'd2, 8'h00);
    // R9: select 3 ignored
    wr(2'd3, 8'hAA);
    // R8: pad toggles
    for (int k = 0; k < 10; k++) begin @(negedge clk); pad_in = 8'h55 ^ W'(k * 37); end
    // R6: sleep without and with override
    @(negedge clk); sleep = 1; pad_in = 8'hFF;
    repeat (3) @(negedge clk);
    ov_die_en = 8'h0F; ov_die_val = 8'h05;
    repeat (3) @(negedge clk);
    sleep = 0;
    // R3 R4 R5 overrides
    @(negedge clk); ov_pu_en = 8'hA5; ov_pu_val = 8'h0F;
    @(negedge clk); ov_dir_en = 8'hC3; ov_dir_val = 8'h81;
    @(negedge clk); ov_pv_en = 8'hFF; ov_pv_val = 8'h5A;
    // R10: toggle on analog pins during conversion
    @(negedge clk); analog_sel = 8'hFF; conv_busy = 1;
    for (int k = 0; k < 6; k++) begin @(negedge clk); ov_pv_val = ~ov_pv_val; end
    @(negedge clk); conv_busy = 0;
    // random sweep
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      ov_pu_en = $urandom; ov_pu_val = $urandom; ov_dir_en = $urandom; ov_dir_val = $urandom;
      ov_pv_en = $urandom; ov_pv_val = $urandom; ov_die_en = $urandom; ov_die_val = $urandom;
      pad_in = $urandom; sleep = $urandom; conv_busy = $urandom; analog_sel = $urandom;
      wr_en = $urandom; wr_sel = $urandom; wr_data = $urandom;
    end
    @(negedge clk); wr_en = 0;
    repeat (4) @(negedge clk);
    #2;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule